// File: doc/BRIEF.md
# Bus Cycle Loss Profiler

This block passively watches the bus signals of one AHB master and sorts every clock cycle inside a measurement window into exactly one of four kinds: a productive data cycle, a wait-state cycle, an idle cycle, or a grant-latency cycle. It keeps a saturating counter for each kind, a count of all window cycles, and for every slave a count of completed accesses and of the wait-state cycles that slave caused. It never drives the bus.

Software or a test sequencer opens a window with a start pulse and closes it with a stop pulse. On stop, every running counter is copied into a result register and cleared. The block then names the largest non-data loss as the bottleneck. A short sequential division produces the efficiency, which is data cycles over window cycles as an unsigned fraction. When that result is ready, a one-cycle done pulse marks all results as valid.

Data-phase decisions follow AHB pipelining. The transfer type and slave select are captured in each cycle where HREADY is high. The next data phase is judged from that captured address phase.

Top module: `bus_cycle_profiler`

## Requirements
- R1: After reset every result output is zero and `done_o` is low.
- R2: A window opens on a cycle where `win_start_i` is sampled while no window is open. That cycle is not counted. Every following cycle, up to and including the cycle where `win_stop_i` is sampled, falls into exactly one category, so the four results add up to `total_cnt_o` unless a counter saturated. `win_stop_i` with no open window has no effect.
- R3: A cycle with `hbusreq_i` high and `hgrant_i` low is a grant-latency cycle, whatever else holds.
- R4: A data phase is pending when the last cycle with `hready_i` high had `hgrant_i` high, `htrans_i` equal to NONSEQ (2'b10) or SEQ (2'b11), and at least one `hsel_i` bit set. A pending data phase with `hready_i` low is a wait-state cycle.
- R5: A pending data phase with `hready_i` high is a data cycle.
- R6: Every other cycle is idle, including cycles after IDLE (2'b00) or BUSY (2'b01) address phases and cycles after address phases with no slave selected.
- R7: Bit s of `slv_acc_o`'s slice s counts data cycles whose captured select had bit s set. Slice s of `slv_wait_o` counts wait-state cycles whose captured select had bit s set. Slice s occupies bits [s*CNT_W +: CNT_W].
- R8: `bottleneck_o` names the largest of the wait, idle and grant results: 0 = wait, 1 = idle, 2 = grant. Ties go to wait, then idle.
- R9: `eff_o` equals floor(data*2^EFF_W/total). It is 2^EFF_W-1 when data equals total, and 0 when total is 0. For example, 3 data cycles out of 8 gives 96.
- R10: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R11: `done_o` is high for exactly one cycle, EFF_W+1 cycles after the stop cycle. The results hold until the next stop, and the next window starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| htrans_i | input | 2 | Observed transfer type |
| hready_i | input | 1 | Observed ready |
| hbusreq_i | input | 1 | Master's bus request |
| hgrant_i | input | 1 | Master's bus grant |
| hsel_i | input | NUM_SLV | Decoded slave selects |
| win_start_i | input | 1 | Open a measurement window |
| win_stop_i | input | 1 | Close the window (cycle counted) |
| data_cnt_o | output | CNT_W | Data cycles in last window |
| wait_cnt_o | output | CNT_W | Wait-state cycles |
| idle_cnt_o | output | CNT_W | Idle cycles |
| grant_cnt_o | output | CNT_W | Grant-latency cycles |
| total_cnt_o | output | CNT_W | All window cycles |
| slv_acc_o | output | NUM_SLV*CNT_W | Per-slave access counts |
| slv_wait_o | output | NUM_SLV*CNT_W | Per-slave wait-state counts |
| bottleneck_o | output | 2 | Dominant non-data category |
| eff_o | output | EFF_W | Efficiency fraction |
| done_o | output | 1 | Results valid pulse |

## Verification
A hand-built eight-cycle window holds 3 data, 2 wait, 2 idle and 1 grant cycle. It tests the category priority, the 96 efficiency and the wait-over-idle tie. Further directed windows make grant, then idle, dominate. They also force a grant-versus-idle tie, an all-data window (efficiency at full scale) and an all-idle run long enough to saturate the counters. Many windows of random length with random transfer types, ready, request, grant and one-hot or empty selects separate errors in the pipelined capture, the priority order and the per-slave attribution. A stray stop with no open window must produce no done pulse.

// File: rtl/prof_pkg.sv
package prof_pkg;
  typedef enum logic [1:0] {CAT_IDLE = 2'd0, CAT_DATA = 2'd1, CAT_WAIT = 2'd2, CAT_GRANT = 2'd3} cat_e;
  typedef enum logic [1:0] {BN_WAIT = 2'd0, BN_IDLE = 2'd1, BN_GRANT = 2'd2} bn_e;
endpackage

// File: rtl/cycle_classifier.sv
module cycle_classifier
  import prof_pkg::*;
#(
  parameter int NUM_SLV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         htrans_i,
  input  logic               hready_i,
  input  logic               hbusreq_i,
  input  logic               hgrant_i,
  input  logic [NUM_SLV-1:0] hsel_i,
  output cat_e               cat_o,
  output logic [NUM_SLV-1:0] dp_sel_o
);
  logic               dp_vld_q;
  logic [NUM_SLV-1:0] dp_sel_q;
  logic               addr_ok;

  // htrans[1] set means NONSEQ or SEQ
  assign addr_ok = hgrant_i & htrans_i[1] & (|hsel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_vld_q <= 1'b0;
      dp_sel_q <= '0;
    end else if (hready_i) begin
      dp_vld_q <= addr_ok;
      dp_sel_q <= addr_ok ? hsel_i : '0;
    end
  end

  always_comb begin
    if (hbusreq_i && !hgrant_i)   cat_o = CAT_GRANT;
    else if (dp_vld_q && !hready_i) cat_o = CAT_WAIT;
    else if (dp_vld_q)            cat_o = CAT_DATA;
    else                          cat_o = CAT_IDLE;
  end

  assign dp_sel_o = dp_sel_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cnt_q;

  assign nxt_o = (inc_i && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end
endmodule

// File: rtl/frac_divider.sv
module frac_divider #(
  parameter int W  = 32,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  num_i,
  input  logic [W-1:0]  den_i,
  output logic [FW-1:0] q_o,
  output logic          done_o
);
  localparam int SW = (FW > 1) ? $clog2(FW) : 1;

  logic [W:0]    rem_q, rem_sh;
  logic [W-1:0]  den_q;
  logic [FW-1:0] q_q, q_nxt;
  logic [SW-1:0] step_q;
  logic          busy_q, zero_q, ge;

  assign rem_sh = {rem_q[W-1:0], 1'b0};
  assign ge     = rem_sh >= {1'b0, den_q};
  assign q_nxt  = {q_q[FW-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; den_q <= '0; q_q <= '0; step_q <= '0;
      busy_q <= 1'b0; zero_q <= 1'b0; q_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        zero_q <= (den_i == '0);
        q_q    <= '0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? rem_sh - {1'b0, den_q} : rem_sh;
        q_q    <= q_nxt;
        step_q <= step_q + 1'b1;
        if (step_q == SW'(FW - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          q_o    <= zero_q ? '0 : q_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/bus_cycle_profiler.sv
module bus_cycle_profiler
  import prof_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int CNT_W   = 32,
  parameter int EFF_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               htrans_i,
  input  logic                     hready_i,
  input  logic                     hbusreq_i,
  input  logic                     hgrant_i,
  input  logic [NUM_SLV-1:0]       hsel_i,
  input  logic                     win_start_i,
  input  logic                     win_stop_i,
  output logic [CNT_W-1:0]         data_cnt_o,
  output logic [CNT_W-1:0]         wait_cnt_o,
  output logic [CNT_W-1:0]         idle_cnt_o,
  output logic [CNT_W-1:0]         grant_cnt_o,
  output logic [CNT_W-1:0]         total_cnt_o,
  output logic [NUM_SLV*CNT_W-1:0] slv_acc_o,
  output logic [NUM_SLV*CNT_W-1:0] slv_wait_o,
  output logic [1:0]               bottleneck_o,
  output logic [EFF_W-1:0]         eff_o,
  output logic                     done_o
);
  localparam int NCAT = 4;

  cat_e               cat;
  logic [NUM_SLV-1:0] dp_sel;
  logic               active_q, open_w, close_w, clr;
  logic [CNT_W-1:0]   cat_nxt [NCAT];
  logic [CNT_W-1:0]   tot_nxt;
  logic [CNT_W-1:0]   acc_nxt [NUM_SLV];
  logic [CNT_W-1:0]   wt_nxt  [NUM_SLV];
  bn_e                bn_nxt;

  assign open_w  = win_start_i & ~active_q;
  assign close_w = win_stop_i & active_q;
  assign clr     = open_w | close_w;

  cycle_classifier #(.NUM_SLV(NUM_SLV)) i_cls (
    .clk_i, .rst_ni, .htrans_i, .hready_i, .hbusreq_i, .hgrant_i, .hsel_i,
    .cat_o(cat), .dp_sel_o(dp_sel)
  );

  for (genvar k = 0; k < NCAT; k++) begin : g_cat
    sat_counter #(.W(CNT_W)) i_cnt (
      .clk_i, .rst_ni, .clr_i(clr),
      .inc_i(active_q && cat == cat_e'(k)), .nxt_o(cat_nxt[k])
    );
  end

  sat_counter #(.W(CNT_W)) i_tot (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(active_q), .nxt_o(tot_nxt)
  );

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
    sat_counter #(.W(CNT_W)) i_acc (
      .clk_i, .rst_ni, .clr_i(clr),
      .inc_i(active_q && cat == CAT_DATA && dp_sel[s]), .nxt_o(acc_nxt[s])
    );
    sat_counter #(.W(CNT_W)) i_wt (
      .clk_i, .rst_ni, .clr_i(clr),
      .inc_i(active_q && cat == CAT_WAIT && dp_sel[s]), .nxt_o(wt_nxt[s])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slv_acc_o[s*CNT_W +: CNT_W]  <= '0;
        slv_wait_o[s*CNT_W +: CNT_W] <= '0;
      end else if (close_w) begin
        slv_acc_o[s*CNT_W +: CNT_W]  <= acc_nxt[s];
        slv_wait_o[s*CNT_W +: CNT_W] <= wt_nxt[s];
      end
    end
  end

  // ties resolve wait, then idle, then grant
  always_comb begin
    if (cat_nxt[CAT_WAIT] >= cat_nxt[CAT_IDLE] && cat_nxt[CAT_WAIT] >= cat_nxt[CAT_GRANT])
      bn_nxt = BN_WAIT;
    else if (cat_nxt[CAT_IDLE] >= cat_nxt[CAT_GRANT])
      bn_nxt = BN_IDLE;
    else
      bn_nxt = BN_GRANT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      data_cnt_o <= '0; wait_cnt_o <= '0; idle_cnt_o <= '0; grant_cnt_o <= '0;
      total_cnt_o <= '0; bottleneck_o <= '0;
    end else begin
      if (open_w)  active_q <= 1'b1;
      if (close_w) begin
        active_q     <= 1'b0;
        data_cnt_o   <= cat_nxt[CAT_DATA];
        wait_cnt_o   <= cat_nxt[CAT_WAIT];
        idle_cnt_o   <= cat_nxt[CAT_IDLE];
        grant_cnt_o  <= cat_nxt[CAT_GRANT];
        total_cnt_o  <= tot_nxt;
        bottleneck_o <= bn_nxt;
      end
    end
  end

  frac_divider #(.W(CNT_W), .FW(EFF_W)) i_div (
    .clk_i, .rst_ni, .start_i(close_w),
    .num_i(cat_nxt[CAT_DATA]), .den_i(tot_nxt),
    .q_o(eff_o), .done_o
  );
endmodule

// File: rtl/prof_chk.sv
module prof_chk #(
  parameter int NUM_SLV = 4,
  parameter int CNT_W   = 32,
  parameter int EFF_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hbusreq_i,
  input logic             hgrant_i,
  input logic             active_q,
  input logic [1:0]       cat,
  input logic [CNT_W-1:0] data_cnt_o,
  input logic [CNT_W-1:0] wait_cnt_o,
  input logic [CNT_W-1:0] idle_cnt_o,
  input logic [CNT_W-1:0] grant_cnt_o,
  input logic [CNT_W-1:0] total_cnt_o,
  input logic [1:0]       bottleneck_o,
  input logic [EFF_W-1:0] eff_o,
  input logic             done_o
);
  localparam int SW = CNT_W + 2;
  localparam int PW = CNT_W + EFF_W + 1;

  logic [SW-1:0] sum;
  logic [PW-1:0] lhs, lhs_hi, num;
  logic [CNT_W-1:0] bn_val;

  assign sum    = SW'(data_cnt_o) + SW'(wait_cnt_o) + SW'(idle_cnt_o) + SW'(grant_cnt_o);
  assign lhs    = PW'(eff_o) * PW'(total_cnt_o);
  assign lhs_hi = lhs + PW'(total_cnt_o);
  assign num    = PW'(data_cnt_o) << EFF_W;

  always_comb begin
    case (bottleneck_o)
      2'd0:    bn_val = wait_cnt_o;
      2'd1:    bn_val = idle_cnt_o;
      default: bn_val = grant_cnt_o;
    endcase
  end

  // R3
  grant_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hbusreq_i && !hgrant_i) |-> cat == 2'd3);

  // R2
  cat_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && total_cnt_o != '1) |-> sum == SW'(total_cnt_o));

  // R8
  bottleneck_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bottleneck_o != 2'd3 && bn_val >= wait_cnt_o && bn_val >= idle_cnt_o
                && bn_val >= grant_cnt_o));

  // R9
  eff_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && total_cnt_o != '0 && data_cnt_o < total_cnt_o) |-> (lhs <= num && lhs_hi > num));

  // R10
  data_le_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> data_cnt_o <= total_cnt_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !done_o);
endmodule

bind bus_cycle_profiler prof_chk #(.NUM_SLV(NUM_SLV), .CNT_W(CNT_W), .EFF_W(EFF_W)) i_prof_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hbusreq_i(hbusreq_i), .hgrant_i(hgrant_i),
  .active_q(active_q), .cat(cat), .data_cnt_o(data_cnt_o), .wait_cnt_o(wait_cnt_o),
  .idle_cnt_o(idle_cnt_o), .grant_cnt_o(grant_cnt_o), .total_cnt_o(total_cnt_o),
  .bottleneck_o(bottleneck_o), .eff_o(eff_o), .done_o(done_o)
);

// File: tb/test_bus_cycle_profiler.sv
module test_bus_cycle_profiler;
  localparam int NS   = 3;
  localparam int CW   = 8;
  localparam int EW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] htrans_i = 2'b00;
  logic hready_i = 1'b1, hbusreq_i = 1'b0, hgrant_i = 1'b1;
  logic [NS-1:0] hsel_i = '0;
  logic win_start_i = 1'b0, win_stop_i = 1'b0;
  logic [CW-1:0] data_cnt_o, wait_cnt_o, idle_cnt_o, grant_cnt_o, total_cnt_o;
  logic [NS*CW-1:0] slv_acc_o, slv_wait_o;
  logic [1:0] bottleneck_o;
  logic [EW-1:0] eff_o;
  logic done_o;

  int n_chk = 0, n_bad = 0;

  // bench model state
  bit act = 0, dpv = 0;
  logic [NS-1:0] dps = '0;
  int c_d, c_w, c_i, c_g, c_t;
  int c_acc[NS], c_wt[NS];
  int x_d, x_w, x_i, x_g, x_t;
  int x_acc[NS], x_wt[NS];

  always #10 clk_i = ~clk_i;

  bus_cycle_profiler #(.NUM_SLV(NS), .CNT_W(CW), .EFF_W(EW)) i_bus_cycle_profiler (.*);

  function automatic int sat(int v);
    return (v < MAXC) ? v + 1 : v;
  endfunction

  task automatic chk(string tag, int act_v, int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  task automatic clr_model();
    c_d = 0; c_w = 0; c_i = 0; c_g = 0; c_t = 0;
    for (int s = 0; s < NS; s++) begin c_acc[s] = 0; c_wt[s] = 0; end
  endtask

  // one cycle: drive at negedge, update model, advance to next negedge
  task automatic cyc(logic [1:0] tr, logic rdy, logic req, logic gnt,
                     logic [NS-1:0] sel, logic st, logic sp);
    int k;
    htrans_i = tr; hready_i = rdy; hbusreq_i = req; hgrant_i = gnt;
    hsel_i = sel; win_start_i = st; win_stop_i = sp;
    if (req && !gnt) k = 3;
    else if (dpv && !rdy) k = 2;
    else if (dpv) k = 1;
    else k = 0;
    if (act) begin
      c_t = sat(c_t);
      case (k)
        0: c_i = sat(c_i);
        1: c_d = sat(c_d);
        2: c_w = sat(c_w);
        default: c_g = sat(c_g);
      endcase
      for (int s = 0; s < NS; s++) if (dps[s]) begin
        if (k == 1) c_acc[s] = sat(c_acc[s]);
        if (k == 2) c_wt[s] = sat(c_wt[s]);
      end
    end
    if (act && sp) begin
      x_d = c_d; x_w = c_w; x_i = c_i; x_g = c_g; x_t = c_t;
      for (int s = 0; s < NS; s++) begin x_acc[s] = c_acc[s]; x_wt[s] = c_wt[s]; end
      clr_model(); act = 0;
    end else if (!act && st) begin
      clr_model(); act = 1;
    end
    if (rdy) begin
      dpv = gnt && tr[1] && (sel != '0);
      dps = dpv ? sel : '0;
    end
    @(negedge clk_i);
  endtask

  task automatic quiet(); cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b0); endtask

  task automatic check_results();
    int bn, eff, seen;
    seen = 0;
    for (int t = 0; t < 20 && !seen; t++) begin
      if (done_o) seen = 1; else quiet();
    end
    chk("R11 done seen", seen, 1);
    // R2 R3 R4 R5 R6 counts
    chk("R5 data", int'(data_cnt_o), x_d);
    chk("R4 wait", int'(wait_cnt_o), x_w);
    chk("R6 idle", int'(idle_cnt_o), x_i);
    chk("R3 grant", int'(grant_cnt_o), x_g);
    chk("R2 total", int'(total_cnt_o), x_t);
    for (int s = 0; s < NS; s++) begin
      chk("R7 acc", int'(slv_acc_o[s*CW +: CW]), x_acc[s]);
      chk("R7 wait", int'(slv_wait_o[s*CW +: CW]), x_wt[s]);
    end
    if (x_w >= x_i && x_w >= x_g) bn = 0;
    else if (x_i >= x_g) bn = 1;
    else bn = 2;
    chk("R8 bottleneck", int'(bottleneck_o), bn);
    if (x_t == 0) eff = 0;
    else if (x_d >= x_t) eff = (1 << EW) - 1;
    else eff = (x_d << EW) / x_t;
    chk("R9 eff", int'(eff_o), eff);
    quiet();
    chk("R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic rand_window(int len);
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
    for (int n = 1; n <= len; n++) begin
      logic [NS-1:0] sel;
      int r;
      r = $urandom_range(0, NS);
      sel = (r == NS) ? '0 : NS'(1 << r);
      cyc(2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 7),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0),
          sel, 1'b0, (n == len));
    end
    check_results();
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr_model();
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 data", int'(data_cnt_o), 0);
    chk("R1 total", int'(total_cnt_o), 0);
    chk("R1 eff", int'(eff_o), 0);
    chk("R1 done", int'(done_o), 0);

    // R2 stop with no open window is ignored
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b1);
    for (int t = 0; t < 12; t++) begin
      chk("R2 stray stop no done", int'(done_o), 0);
      quiet();
    end

    // 3 data, 2 wait, 2 idle, 1 grant -> eff 96, wait/idle tie -> wait
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
    cyc(2'b00, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);       // grant
    cyc(2'b10, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);   // idle
    cyc(2'b11, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);   // data
    cyc(2'b11, 1'b0, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);   // wait
    cyc(2'b11, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);   // data
    cyc(2'b11, 1'b0, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);   // wait
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b0);       // data
    cyc(2'b01, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0, 1'b1);   // idle, stop
    check_results();
    chk("R9 example eff", int'(eff_o), 96);
    chk("R8 tie picks wait", int'(bottleneck_o), 0);

    // grant dominant, grant also overrides pending wait (R3)
    cyc(2'b10, 1'b1, 1'b0, 1'b1, 3'b001, 1'b1, 1'b0);
    for (int n = 0; n < 5; n++) cyc(2'b10, 1'b0, 1'b1, 1'b0, 3'b001, 1'b0, 1'b0);
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b1);
    check_results();
    chk("R8 grant dominant", int'(bottleneck_o), 2);

    // grant/idle tie picks idle
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
    cyc(2'b00, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    cyc(2'b00, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    cyc(2'b01, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, 1'b0);
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, 1'b1);
    check_results();
    chk("R8 tie picks idle", int'(bottleneck_o), 1);

    // all-data window: eff full scale, slave 2 accesses
    cyc(2'b10, 1'b1, 1'b0, 1'b1, 3'b100, 1'b1, 1'b0);
    for (int n = 0; n < 6; n++) cyc(2'b11, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, (n == 5));
    check_results();
    chk("R9 full eff", int'(eff_o), 255);
    chk("R7 slave2 acc", int'(slv_acc_o[2*CW +: CW]), 6);

    // saturation: 300 idle cycles
    cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
    for (int n = 0; n < 300; n++) cyc(2'b00, 1'b1, 1'b0, 1'b1, '0, 1'b0, (n == 299));
    check_results();
    chk("R10 idle sat", int'(idle_cnt_o), MAXC);
    chk("R10 total sat", int'(total_cnt_o), MAXC);

    // random sweep
    for (int w = 0; w < 60; w++) rand_window($urandom_range(1, 200));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule